// File: doc/BRIEF.md
# Dual-Endian CSR Target Decoder

This block is a target-side front end for a bank of 32-bit control and status registers. A bus master issues single-cycle requests carrying a valid flag, a write flag, a byte address, four byte enables and write data. The block checks the address against a 1 KB memory window and a 256-byte I/O window, both placed by static base-address inputs aligned to their sizes, and turns a hit into a register-bank read or write. A request that hits neither window touches nothing and gets no answer.

The memory window carries the same registers twice. Its lower half is a little-endian view; its upper half is a big-endian view in which write data is byte-reversed before it is stored and read data is byte-reversed before it is returned. The I/O window always uses little-endian order. Only whole-word writes change a register: a write with any byte enable low is dropped without any error. A read returns the whole word whatever its byte enables. Reads never change state. Read data comes back with a one-cycle strobe in the cycle after the request.

Top module: `csr_dual_endian_target`

## Requirements
- R1: After reset `rsp_valid` is 0 and every register reads as zero through every view.
- R2: A read or full write at memory offset 0x000-0x1FF (offset bit 9 = 0) uses little-endian order: the stored word equals `req_wdata`, and read data equals the stored word. Offset bits 8:2 give the word index; bits 1:0 are ignored.
- R3: A write whose `req_be` is not 4'b1111 changes no register in any window.
- R4: A read returns all 32 bits of the addressed register for every value of `req_be`.
- R5: A full write at memory offset 0x200-0x3FF (offset bit 9 = 1) stores the byte-reversed data: byte lane 0 of `req_wdata` lands in bits 31:24, lane 3 in bits 7:0.
- R6: A read at memory offset 0x200-0x3FF returns the stored word byte-reversed in the same lane order as R5.
- R7: The I/O window reaches the same registers in little-endian order, with offset bits 7:2 as the word index.
- R8: A request whose address falls in neither window writes nothing and raises no `rsp_valid`.
- R9: `rsp_valid` is high for exactly the cycle after an accepted read request and stays low after writes and idle cycles; `rsp_rdata` is valid in that cycle.
- R10: Memory word indices from 64 to 127 in either view read as zero and ignore writes, while still answering reads.
- R11: Reading a register leaves its contents unchanged; repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_base | input | 32 | Memory window base address, 1 KB aligned, static |
| io_base | input | 32 | I/O window base address, 256-byte aligned, static |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address of the request |
| req_be | input | 4 | Byte enables, one per byte lane |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data strobe, one cycle after a hit read |
| rsp_rdata | output | 32 | Read data, valid with `rsp_valid` |

## Verification
Stimulus mixes seeded random requests spread over the little-endian half, the big-endian half, the I/O window and addresses outside both, so that a value written through one view and read through another shows whether the lane reversal is applied exactly once on each path. Byte enables are mostly full with a share of random partial patterns, which separates a dropped partial write from a merged one and shows whether reads ignore the enables. Word indices above the bank size in the memory halves tell the out-of-bank path from aliasing onto low registers, and directed cases cover the reset state, a known pattern through both views and repeated reads.

// File: rtl/csr_tgt_pkg.sv
package csr_tgt_pkg;

   // Which window, and which view of it, a request lands in
   typedef enum logic [1:0] {
      WIN_NONE   = 2'd0,
      WIN_MEM_LE = 2'd1,
      WIN_MEM_BE = 2'd2,
      WIN_IO     = 2'd3
   } win_sel_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/csr_lane_swap.sv
module csr_lane_swap #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / LANE_W;

   logic [DATA_W-1:0] reversed;

   initial begin : p_param_chk
      if ((DATA_W % LANE_W) != 0)
         $fatal(1, "csr_lane_swap: DATA_W must be a multiple of LANE_W");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign reversed[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
   end

   assign dout = swap ? reversed : din;

endmodule

// File: rtl/csr_window_decode.sv
module csr_window_decode
   import csr_tgt_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int BE_W          = 4,
   parameter int MEM_WIN_BYTES = 1024,
   parameter int IO_WIN_BYTES  = 256,
   parameter int REG_WORDS     = 64,
   parameter int BANK_IDX_W    = 6
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [ADDR_W-1:0]     mem_base,
   input  logic [ADDR_W-1:0]     io_base,
   input  logic [BE_W-1:0]       be,
   output win_sel_e              win,
   output logic [BANK_IDX_W-1:0] bank_idx,
   output logic                  in_bank,
   output logic                  full_be
);
   localparam int LANE_LSB = $clog2(BE_W);
   localparam int MEM_LOG  = $clog2(MEM_WIN_BYTES);
   localparam int IO_LOG   = $clog2(IO_WIN_BYTES);
   localparam int VIEW_BIT = MEM_LOG - 1;
   localparam int OFS_W    = VIEW_BIT - LANE_LSB;
   localparam int IO_OFS_W = IO_LOG - LANE_LSB;

   initial begin : p_param_chk
      if (!is_pow2(MEM_WIN_BYTES) || !is_pow2(IO_WIN_BYTES) || !is_pow2(BE_W))
         $fatal(1, "csr_window_decode: window sizes and BE_W must be powers of two");
      if (IO_WIN_BYTES > MEM_WIN_BYTES / 2)
         $fatal(1, "csr_window_decode: I/O window larger than one memory view");
      if (REG_WORDS > (1 << OFS_W))
         $fatal(1, "csr_window_decode: bank larger than one memory view");
      if (BANK_IDX_W != $clog2(REG_WORDS))
         $fatal(1, "csr_window_decode: BANK_IDX_W mismatch");
   end

   logic             mem_match;
   logic             io_match;
   logic [OFS_W-1:0] mem_ofs;
   logic [OFS_W-1:0] io_ofs;
   logic [OFS_W-1:0] word_ofs;

   assign mem_match = (addr[ADDR_W-1:MEM_LOG] == mem_base[ADDR_W-1:MEM_LOG]);
   assign io_match  = (addr[ADDR_W-1:IO_LOG]  == io_base[ADDR_W-1:IO_LOG]);
   assign mem_ofs   = addr[VIEW_BIT-1:LANE_LSB];

   // Pad the shorter I/O offset up to the memory-view offset width
   if (IO_OFS_W == OFS_W) begin : g_io_same
      assign io_ofs = addr[IO_LOG-1:LANE_LSB];
   end else begin : g_io_pad
      assign io_ofs = {{(OFS_W-IO_OFS_W){1'b0}}, addr[IO_LOG-1:LANE_LSB]};
   end

   // Memory window takes priority if a mis-programmed base overlaps
   always_comb begin
      if (mem_match)
         win = addr[VIEW_BIT] ? WIN_MEM_BE : WIN_MEM_LE;
      else if (io_match)
         win = WIN_IO;
      else
         win = WIN_NONE;
   end

   assign word_ofs = (win == WIN_IO) ? io_ofs : mem_ofs;
   assign in_bank  = (32'(word_ofs) < REG_WORDS);
   assign bank_idx = word_ofs[BANK_IDX_W-1:0];
   assign full_be  = &be;

   logic unused_addr_bits;
   assign unused_addr_bits = ^{addr[LANE_LSB-1:0], mem_base[MEM_LOG-1:0], io_base[IO_LOG-1:0]};

endmodule

// File: rtl/csr_word_bank.sv
module csr_word_bank #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] words [WORDS];

   initial begin : p_param_chk
      if (WORDS > (1 << IDX_W))
         $fatal(1, "csr_word_bank: IDX_W too narrow for WORDS");
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[w] <= '0;
         else if (we && (32'(idx) == w))
            words[w] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < WORDS; w++)
         if (32'(idx) == w) rdata = words[w];
   end

endmodule

// File: rtl/csr_dual_endian_target.sv
module csr_dual_endian_target
   import csr_tgt_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter int MEM_WIN_BYTES = 1024,
   parameter int IO_WIN_BYTES  = 256,
   parameter int REG_WORDS     = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   mem_base,
   input  logic [ADDR_W-1:0]   io_base,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata
);
   localparam int BE_W       = DATA_W / 8;
   localparam int BANK_IDX_W = $clog2(REG_WORDS);

   initial begin : p_param_chk
      if (DATA_W % 8 != 0)
         $fatal(1, "csr_dual_endian_target: DATA_W must be whole bytes");
      if (REG_WORDS < 2)
         $fatal(1, "csr_dual_endian_target: REG_WORDS must be at least 2");
   end

   win_sel_e              win;
   logic [BANK_IDX_W-1:0] bank_idx;
   logic                  in_bank;
   logic                  full_be;
   logic                  hit;
   logic                  swap;
   logic                  bank_we;
   logic [DATA_W-1:0]     bank_wdata;
   logic [DATA_W-1:0]     bank_rdata;
   logic [DATA_W-1:0]     rd_word;
   logic [DATA_W-1:0]     rd_ret;
   logic                  rd_take;

   csr_window_decode #(
      .ADDR_W       (ADDR_W),
      .BE_W         (BE_W),
      .MEM_WIN_BYTES(MEM_WIN_BYTES),
      .IO_WIN_BYTES (IO_WIN_BYTES),
      .REG_WORDS    (REG_WORDS),
      .BANK_IDX_W   (BANK_IDX_W)
   ) i_decode (
      .addr    (req_addr),
      .mem_base(mem_base),
      .io_base (io_base),
      .be      (req_be),
      .win     (win),
      .bank_idx(bank_idx),
      .in_bank (in_bank),
      .full_be (full_be)
   );

   assign hit  = (win != WIN_NONE);
   assign swap = (win == WIN_MEM_BE);

   // Only whole-word writes to an existing register reach the bank
   assign bank_we = req_valid && req_write && hit && full_be && in_bank;

   csr_lane_swap #(.DATA_W(DATA_W), .LANE_W(8)) i_wr_swap (
      .swap(swap),
      .din (req_wdata),
      .dout(bank_wdata)
   );

   csr_word_bank #(.DATA_W(DATA_W), .WORDS(REG_WORDS), .IDX_W(BANK_IDX_W)) i_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bank_we),
      .idx  (bank_idx),
      .wdata(bank_wdata),
      .rdata(bank_rdata)
   );

   assign rd_word = in_bank ? bank_rdata : '0;

   csr_lane_swap #(.DATA_W(DATA_W), .LANE_W(8)) i_rd_swap (
      .swap(swap),
      .din (rd_word),
      .dout(rd_ret)
   );

   assign rd_take = req_valid && !req_write && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_take;
         if (rd_take) rsp_rdata <= rd_ret;
      end
   end

endmodule

// File: rtl/csr_tgt_chk.sv
module csr_tgt_chk #(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter int MEM_WIN_BYTES = 1024,
   parameter int IO_WIN_BYTES  = 256
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   mem_base,
   input logic [ADDR_W-1:0]   io_base,
   input logic                req_valid,
   input logic                req_write,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [DATA_W/8-1:0] req_be,
   input logic [DATA_W-1:0]   req_wdata,
   input logic                rsp_valid,
   input logic                bank_we,
   input logic [DATA_W-1:0]   bank_wdata
);
   localparam int MEM_LOG = $clog2(MEM_WIN_BYTES);
   localparam int IO_LOG  = $clog2(IO_WIN_BYTES);
   localparam int LANES   = DATA_W / 8;

   function automatic logic [DATA_W-1:0] rev_lanes(input logic [DATA_W-1:0] d);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < LANES; i++) r[i*8 +: 8] = d[(LANES-1-i)*8 +: 8];
      return r;
   endfunction

   logic mem_in;
   logic io_in;
   logic any_in;
   logic be_view;

   assign mem_in  = (req_addr[ADDR_W-1:MEM_LOG] == mem_base[ADDR_W-1:MEM_LOG]);
   assign io_in   = (req_addr[ADDR_W-1:IO_LOG]  == io_base[ADDR_W-1:IO_LOG]);
   assign any_in  = mem_in || io_in;
   assign be_view = mem_in && req_addr[MEM_LOG-1];

   // R9
   rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write && any_in));

   // R9
   write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid);

   // R8
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_in) |=> !rsp_valid);

   // R8
   miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_in |-> !bank_we);

   // R3
   partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !(&req_be)) |-> !bank_we);

   // R5
   be_swap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_we && be_view) |-> (bank_wdata == rev_lanes(req_wdata)));

   // R2
   le_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_we && !be_view) |-> (bank_wdata == req_wdata));

endmodule

bind csr_dual_endian_target csr_tgt_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .MEM_WIN_BYTES(MEM_WIN_BYTES),
   .IO_WIN_BYTES (IO_WIN_BYTES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_base  (mem_base),
   .io_base   (io_base),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_be    (req_be),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .bank_we   (bank_we),
   .bank_wdata(bank_wdata)
);

// File: tb/test_csr_dual_endian_target.sv
module test_csr_dual_endian_target;
   localparam int CLK_P = 10;
   localparam logic [31:0] MEM_BASE = 32'h0001_0000;
   localparam logic [31:0] IO_BASE  = 32'h0000_2000;
   localparam logic [31:0] FAR_ADDR = 32'h5000_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_write;
   logic [31:0] req_addr;
   logic [3:0]  req_be;
   logic [31:0] req_wdata;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;

   int n_run  = 0;
   int n_fail = 0;
   logic [31:0] shadow [64];

   always #(CLK_P/2) clk = ~clk;

   csr_dual_endian_target i_csr_dual_endian_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .mem_base (MEM_BASE),
      .io_base  (IO_BASE),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_addr (req_addr),
      .req_be   (req_be),
      .req_wdata(req_wdata),
      .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata)
   );

   function automatic logic [31:0] bswap(input logic [31:0] d);
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

   // 0 outside, 1 memory little-endian, 2 memory big-endian, 3 I/O
   function automatic int region(input logic [31:0] a);
      if (a[31:10] == MEM_BASE[31:10]) return a[9] ? 2 : 1;
      if (a[31:8] == IO_BASE[31:8]) return 3;
      return 0;
   endfunction

   function automatic int word_of(input logic [31:0] a);
      return (region(a) == 3) ? int'(a[7:2]) : int'(a[8:2]);
   endfunction

   function automatic logic [31:0] mem_addr(input bit big, input int idx);
      return MEM_BASE + (big ? 32'h200 : 32'h0) + 32'(idx * 4);
   endfunction

   function automatic logic [31:0] io_addr(input int idx);
      return IO_BASE + 32'(idx * 4);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] a, input logic [3:0] be,
                           input logic [31:0] d, input string tag);
      int r;
      int w;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check(rsp_valid == 1'b0, {tag, " R9 no strobe after write"}, 32'(rsp_valid), 32'd0);
      r = region(a);
      w = word_of(a);
      if (r != 0 && be == 4'hF && w < 64)
         shadow[w] = (r == 2) ? bswap(d) : d;
   endtask

   task automatic do_read(input logic [31:0] a, input logic [3:0] be, input string tag);
      int r;
      int w;
      logic [31:0] exp;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      req_valid = 1'b0;
      r = region(a);
      w = word_of(a);
      if (r == 0) begin
         check(rsp_valid == 1'b0, {tag, " R8 no strobe on miss"}, 32'(rsp_valid), 32'd0);
      end else begin
         exp = (w < 64) ? shadow[w] : 32'd0;
         if (r == 2) exp = bswap(exp);
         check(rsp_valid == 1'b1, {tag, " R9 strobe"}, 32'(rsp_valid), 32'd1);
         check(rsp_rdata == exp, {tag, " data"}, rsp_rdata, exp);
      end
   endtask

   initial begin : p_watchdog
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : p_main
      logic [31:0] a;
      logic [3:0]  be;
      string       tag;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) shadow[i] = '0;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_be = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(rsp_valid == 1'b0, "R1 strobe low after reset", 32'(rsp_valid), 32'd0);

      // R1: every view reads zero after reset
      do_read(mem_addr(0, 0), 4'hF, "R1 le idx0");
      do_read(mem_addr(1, 63), 4'hF, "R1 be idx63");
      do_read(io_addr(17), 4'hF, "R1 io idx17");

      // R2, R6, R7: one pattern seen through all three views
      do_write(mem_addr(0, 5), 4'hF, 32'h1122_3344, "R2 le write");
      do_read(mem_addr(0, 5), 4'hF, "R2 le read");
      do_read(mem_addr(1, 5), 4'hF, "R6 be read");
      do_read(io_addr(5), 4'hF, "R7 io read");

      // R5: big-endian write stored reversed, seen through little-endian
      do_write(mem_addr(1, 9), 4'hF, 32'hA1B2_C3D4, "R5 be write");
      do_read(mem_addr(0, 9), 4'hF, "R5 le sees reversed");
      check(shadow[9] == 32'hD4C3_B2A1, "R5 model lane order", shadow[9], 32'hD4C3_B2A1);

      // R3: partial writes dropped in every window
      do_write(mem_addr(0, 5), 4'h7, 32'hFFFF_FFFF, "R3 le partial");
      do_write(mem_addr(1, 5), 4'h1, 32'hFFFF_FFFF, "R3 be partial");
      do_write(io_addr(5), 4'h0, 32'hFFFF_FFFF, "R3 io partial");
      do_read(io_addr(5), 4'hF, "R3 unchanged");

      // R4: narrow read returns whole word
      do_read(mem_addr(0, 5), 4'h1, "R4 single lane read");
      do_read(mem_addr(1, 9), 4'h0, "R4 no lane read");

      // R10: words above the bank
      do_write(mem_addr(0, 64), 4'hF, 32'h5555_AAAA, "R10 write high");
      do_read(mem_addr(0, 64), 4'hF, "R10 read high");
      do_read(mem_addr(0, 0), 4'hF, "R10 no alias idx0");

      // R8: outside both windows
      do_write(FAR_ADDR, 4'hF, 32'h0BAD_0BAD, "R8 far write");
      do_write(MEM_BASE + 32'h400, 4'hF, 32'h0BAD_0BAD, "R8 just past mem");
      do_read(FAR_ADDR, 4'hF, "R8 far read");
      do_read(mem_addr(0, 0), 4'hF, "R8 idx0 untouched");

      // R11: repeated reads identical
      do_read(io_addr(9), 4'hF, "R11 first read");
      do_read(io_addr(9), 4'hF, "R11 second read");

      // Seeded random mix over all views
      for (int it = 0; it < 1500; it++) begin
         int sel;
         int idx;
         sel = $urandom_range(0, 9);
         if (sel == 0) begin
            a = ($urandom_range(0, 1) == 0) ? FAR_ADDR + 32'($urandom_range(0, 255) * 4)
                                            : MEM_BASE + 32'h400 + 32'($urandom_range(0, 63) * 4);
            tag = "R8 rnd miss";
         end else if (sel <= 6) begin
            idx = ($urandom_range(0, 3) == 0) ? $urandom_range(64, 127) : $urandom_range(0, 63);
            a = mem_addr(sel > 3, idx);
            tag = (idx >= 64) ? "R10 rnd high" : ((sel > 3) ? "R6 rnd be" : "R2 rnd le");
         end else begin
            a = io_addr($urandom_range(0, 63));
            tag = "R7 rnd io";
         end
         be = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
         if ($urandom_range(0, 1) == 0)
            do_write(a, be, $urandom, (be != 4'hF) ? "R3 rnd partial" : tag);
         else
            do_read(a, be, (be != 4'hF) ? "R4 rnd narrow" : tag);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule